// File: doc/BRIEF.md
# Pipelined Q15 Complex Multiplier

This block forms the product of two complex operands, X and Y. Each real and imaginary part is a 16-bit twos complement fraction (Q15), so its value lies in [-1, 1). Four parallel partial-product multipliers each give a 31-bit fraction. A subtractor then forms the real result and an adder forms the imaginary result, each kept at the full 32 bits. A result that reaches the output has first passed through three register stages: the operand registers, the partial-product registers and the sum registers.

Each operand register has its own active-low load strobe and its own conjugate flag. The one product that cannot be represented, -1 times -1, is replaced by the largest positive fraction. A small combinational stage sits after the sum registers and works from unregistered controls. It applies a coded scaling shift to both results and can round the upper 16-bit half. It flags when a left shift loses the sign, and it routes two 16-bit slices of the results to the two output ports. A system can therefore read all 64 result bits within a single cycle by changing the select code.

Top module: `cplx_q15_mul`

## Requirements
- R1: While reset (rst_n low, asynchronous) is active, all pipeline registers are zero. With rnd_en low this gives p_a = p_b = 0 and ovf = 0 for every out_sel value.
- R2: The X operand register loads x_re/x_im on a rising edge only when x_load_n is low, and the Y operand register loads y_re/y_im only when y_load_n is low. An operand whose strobe is high keeps its previous value, and the data and conjugate inputs of that port have no effect.
- R3: Operands loaded on edge k appear in the results after edge k+2. A new operand pair may be loaded on every edge, giving one result per cycle.
- R4: Each partial product (xr*yr, xr*yi, xi*yr, xi*yi) is the 31-bit signed product with the duplicate sign bit removed, so that bit 30 carries weight -1. When both inputs are 0x8000, the product is replaced by 0x3FFFFFFF.
- R5: The 32-bit real result is xr*yr - xi*yi and the 32-bit imaginary result is xr*yi + xi*yr. Both partial products are sign-extended, and bit 31 of each result carries weight -2.
- R6: When x_conj (or y_conj) is high on the edge that loads X (or Y), the stored imaginary part is the twos complement negation of the input, so 0x8000 stays 0x8000. The two flags act independently.
- R7: shift_code selects a scaling shift that is applied to both results alike: 2'b11 shifts left by one, 2'b00 applies no shift, 2'b01 shifts right by one and 2'b10 shifts right by two. Right shifts are arithmetic.
- R8: ovf is high exactly when shift_code is 2'b11 and bit 31 differs from bit 30 in the unshifted real result, in the unshifted imaginary result, or in both.
- R9: When rnd_en is high, each upper 16-bit word is bits 31:16 of the shifted result plus 0x8000, taken modulo 2^32. The lower words are never changed by rounding. rnd_en acts combinationally.
- R10: out_sel acts combinationally and drives (p_a, p_b) as follows: 2'b00 gives (real upper, imag upper), 2'b10 gives (real lower, imag lower), 2'b01 gives (real upper, real lower) and 2'b11 gives (imag upper, imag lower).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_re | input | 16 | Real part of operand X, Q15 |
| x_im | input | 16 | Imaginary part of operand X, Q15 |
| x_load_n | input | 1 | Active-low load strobe for the X register |
| x_conj | input | 1 | Negate the imaginary part of X while loading it |
| y_re | input | 16 | Real part of operand Y, Q15 |
| y_im | input | 16 | Imaginary part of operand Y, Q15 |
| y_load_n | input | 1 | Active-low load strobe for the Y register |
| y_conj | input | 1 | Negate the imaginary part of Y while loading it |
| shift_code | input | 2 | Scaling shift code for both results |
| rnd_en | input | 1 | Round the upper words, unregistered |
| out_sel | input | 2 | Selects which result slices go to the outputs, unregistered |
| p_a | output | 16 | First selected 16-bit slice |
| p_b | output | 16 | Second selected 16-bit slice |
| ovf | output | 1 | The left shift lost the sign of a result |

## Verification
The directed cases target the -1 times -1 trap with all four parts at 0x8000. In that case the imaginary sum reaches 0x7FFFFFFE. A design without the trap would report a negative real or imaginary value there, and a design that tests the wrong bit pair would miss the left-shift overflow. Other cases conjugate 0x8000, where a design that builds -v as ~v would be off by one LSB. Operands are also loaded one at a time with the other strobe high, so a design that ignores a strobe or applies a conjugate flag to the port that is not loading would produce the wrong product. Random operands are streamed on back-to-back cycles to expose any latency other than two cycles after the operand registers, and every vector is checked under all shift codes and output selects. This catches a logical right shift, rounding applied to the lower words, and swapped output slices.

// File: rtl/cplx_mul_pkg.sv
package cplx_mul_pkg;

   // Scaling shift codes; the encoding is part of the block's interface
   typedef enum logic [1:0] {
      SH_NONE = 2'b00,
      SH_R1   = 2'b01,
      SH_R2   = 2'b10,
      SH_L1   = 2'b11
   } shift_e;

   // Output slice selection codes
   typedef enum logic [1:0] {
      SEL_HI = 2'b00,
      SEL_RE = 2'b01,
      SEL_LO = 2'b10,
      SEL_IM = 2'b11
   } osel_e;

endpackage

// File: rtl/cplx_in_reg.sv
module cplx_in_reg #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_n,
   input  logic          conj,
   input  logic [DW-1:0] re_i,
   input  logic [DW-1:0] im_i,
   output logic [DW-1:0] re_o,
   output logic [DW-1:0] im_o
);

   logic [DW-1:0] im_next;

   // twos complement negation wraps: the most negative code maps to itself
   assign im_next = conj ? DW'(~im_i + 1'b1) : im_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_o <= '0;
         im_o <= '0;
      end else if (!load_n) begin
         re_o <= re_i;
         im_o <= im_next;
      end
   end

endmodule

// File: rtl/cplx_pp.sv
module cplx_pp #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [2*DW-2:0] p_o
);

   localparam int PW = 2 * DW - 1;
   localparam logic [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
   localparam logic [PW-1:0] MAX_P = {1'b0, {(PW-1){1'b1}}};

   logic signed [2*DW-1:0] full;
   logic                   trap;
   logic [PW-1:0]          p_next;

   assign full   = $signed(a) * $signed(b);
   assign trap   = (a == MIN_V) && (b == MIN_V);
   // dropping bit 2*DW-1 removes the duplicate sign bit
   assign p_next = trap ? MAX_P : full[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_o <= '0;
      else        p_o <= p_next;
   end

endmodule

// File: rtl/cplx_sum.sv
module cplx_sum #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2*DW-2:0] pp_rr,
   input  logic [2*DW-2:0] pp_ri,
   input  logic [2*DW-2:0] pp_ir,
   input  logic [2*DW-2:0] pp_ii,
   output logic [2*DW-1:0] re_o,
   output logic [2*DW-1:0] im_o
);

   localparam int PW = 2 * DW - 1;
   localparam int SW = 2 * DW;

   function automatic logic [SW-1:0] sext(input logic [PW-1:0] v);
      return {v[PW-1], v};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_o <= '0;
         im_o <= '0;
      end else begin
         re_o <= sext(pp_rr) - sext(pp_ii);
         im_o <= sext(pp_ri) + sext(pp_ir);
      end
   end

endmodule

// File: rtl/cplx_post.sv
module cplx_post
   import cplx_mul_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [2*DW-1:0] re_s,
   input  logic [2*DW-1:0] im_s,
   input  logic [1:0]      shift_code,
   input  logic            rnd_en,
   input  logic [1:0]      out_sel,
   output logic [DW-1:0]   p_a,
   output logic [DW-1:0]   p_b,
   output logic            ovf
);

   localparam int SW = 2 * DW;
   localparam logic [SW-1:0] HALF = SW'(1) << (DW - 1);

   logic [SW-1:0] lane_s  [2];
   logic [SW-1:0] lane_sh [2];
   logic [SW-1:0] lane_rs [2];
   logic [DW-1:0] lane_hi [2];
   logic [DW-1:0] lane_lo [2];
   logic          lane_ov [2];

   assign lane_s[0] = re_s;
   assign lane_s[1] = im_s;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      always_comb begin
         case (shift_e'(shift_code))
            SH_L1:   lane_sh[g] = lane_s[g] << 1;
            SH_R1:   lane_sh[g] = SW'($signed(lane_s[g]) >>> 1);
            SH_R2:   lane_sh[g] = SW'($signed(lane_s[g]) >>> 2);
            default: lane_sh[g] = lane_s[g];
         endcase
      end
      assign lane_rs[g] = lane_sh[g] + HALF;
      assign lane_hi[g] = rnd_en ? lane_rs[g][SW-1:DW] : lane_sh[g][SW-1:DW];
      assign lane_lo[g] = lane_sh[g][DW-1:0];
      assign lane_ov[g] = (shift_code == SH_L1) && (lane_s[g][SW-1] != lane_s[g][SW-2]);
   end

   assign ovf = lane_ov[0] | lane_ov[1];

   always_comb begin
      case (osel_e'(out_sel))
         SEL_HI:  begin p_a = lane_hi[0]; p_b = lane_hi[1]; end
         SEL_LO:  begin p_a = lane_lo[0]; p_b = lane_lo[1]; end
         SEL_RE:  begin p_a = lane_hi[0]; p_b = lane_lo[0]; end
         SEL_IM:  begin p_a = lane_hi[1]; p_b = lane_lo[1]; end
         default: begin p_a = lane_hi[0]; p_b = lane_hi[1]; end
      endcase
   end

endmodule

// File: rtl/cplx_q15_mul.sv
module cplx_q15_mul
   import cplx_mul_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] x_re,
   input  logic [DW-1:0] x_im,
   input  logic          x_load_n,
   input  logic          x_conj,
   input  logic [DW-1:0] y_re,
   input  logic [DW-1:0] y_im,
   input  logic          y_load_n,
   input  logic          y_conj,
   input  logic [1:0]    shift_code,
   input  logic          rnd_en,
   input  logic [1:0]    out_sel,
   output logic [DW-1:0] p_a,
   output logic [DW-1:0] p_b,
   output logic          ovf
);

   localparam int PW = 2 * DW - 1;
   localparam int SW = 2 * DW;
   localparam int NPP = 4;

   if (DW < 4) begin : g_bad_width
      $error("cplx_q15_mul: DW must be at least 4");
   end

   logic [DW-1:0]      port_re [2];
   logic [DW-1:0]      port_im [2];
   logic               port_ld [2];
   logic               port_cj [2];
   logic [DW-1:0]      op_re   [2];
   logic [DW-1:0]      op_im   [2];
   logic [PW-1:0]      pp      [NPP];
   logic [NPP*PW-1:0]  pp_flat;
   logic [SW-1:0]      sum_re;
   logic [SW-1:0]      sum_im;

   assign port_re[0] = x_re;
   assign port_im[0] = x_im;
   assign port_ld[0] = x_load_n;
   assign port_cj[0] = x_conj;
   assign port_re[1] = y_re;
   assign port_im[1] = y_im;
   assign port_ld[1] = y_load_n;
   assign port_cj[1] = y_conj;

   for (genvar g = 0; g < 2; g++) begin : g_in
      cplx_in_reg #(.DW(DW)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_n (port_ld[g]),
         .conj   (port_cj[g]),
         .re_i   (port_re[g]),
         .im_i   (port_im[g]),
         .re_o   (op_re[g]),
         .im_o   (op_im[g])
      );
   end

   // index k: bit 1 picks the X part (re/im), bit 0 picks the Y part
   for (genvar k = 0; k < NPP; k++) begin : g_pp
      cplx_pp #(.DW(DW)) u_pp (
         .clk   (clk),
         .rst_n (rst_n),
         .a     ((k >= 2)     ? op_im[0] : op_re[0]),
         .b     ((k % 2 == 1) ? op_im[1] : op_re[1]),
         .p_o   (pp[k])
      );
      assign pp_flat[k*PW +: PW] = pp[k];
   end

   cplx_sum #(.DW(DW)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .pp_rr (pp[0]),
      .pp_ri (pp[1]),
      .pp_ir (pp[2]),
      .pp_ii (pp[3]),
      .re_o  (sum_re),
      .im_o  (sum_im)
   );

   cplx_post #(.DW(DW)) u_post (
      .re_s       (sum_re),
      .im_s       (sum_im),
      .shift_code (shift_code),
      .rnd_en     (rnd_en),
      .out_sel    (out_sel),
      .p_a        (p_a),
      .p_b        (p_b),
      .ovf        (ovf)
   );

endmodule

// File: rtl/cplx_mul_chk.sv
module cplx_mul_chk #(
   parameter int DW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 x_load_n,
   input logic                 y_load_n,
   input logic [1:0]           shift_code,
   input logic                 rnd_en,
   input logic [1:0]           out_sel,
   input logic [DW-1:0]        p_a,
   input logic [DW-1:0]        p_b,
   input logic                 ovf,
   input logic [4*(2*DW-1)-1:0] pp_flat
);

   localparam int PW = 2 * DW - 1;
   localparam logic [PW-1:0] NEG_ONE = {1'b1, {(PW-1){1'b0}}};

   logic [2:0] since_rst;
   logic       idle;

   assign idle = x_load_n && y_load_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   // R1: the first edge after reset still sees the cleared pipeline
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && !rnd_en) |-> (p_a == '0 && p_b == '0 && !ovf));

   // R2: with both strobes high for three edges the outputs freeze
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4 && $past(idle, 1) && $past(idle, 2) && $past(idle, 3)
       && $stable(shift_code) && $stable(rnd_en) && $stable(out_sel))
      |-> ($stable(p_a) && $stable(p_b) && $stable(ovf)));

   // R4: the trapped product means no partial product ever equals -1
   for (genvar k = 0; k < 4; k++) begin : g_pp_chk
      a_r4_no_neg_one: assert property (@(posedge clk) disable iff (!rst_n)
         pp_flat[k*PW +: PW] != NEG_ONE);
   end

   // R8: overflow only under the left shift code
   a_r8_ovf_left_only: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_code != 2'b11) |-> !ovf);

endmodule

bind cplx_q15_mul cplx_mul_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .x_load_n   (x_load_n),
   .y_load_n   (y_load_n),
   .shift_code (shift_code),
   .rnd_en     (rnd_en),
   .out_sel    (out_sel),
   .p_a        (p_a),
   .p_b        (p_b),
   .ovf        (ovf),
   .pp_flat    (pp_flat)
);

// File: tb/cplx_q15_mul_tb_top.sv
module cplx_q15_mul_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
   logic          x_load_n = 1'b1, y_load_n = 1'b1, x_conj = 1'b0, y_conj = 1'b0;
   logic [1:0]    shift_code = 2'b00;
   logic          rnd_en = 1'b0;
   logic [1:0]    out_sel = 2'b00;
   logic [DW-1:0] p_a, p_b;
   logic          ovf;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cplx_q15_mul #(.DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .x_re(x_re), .x_im(x_im), .x_load_n(x_load_n), .x_conj(x_conj),
      .y_re(y_re), .y_im(y_im), .y_load_n(y_load_n), .y_conj(y_conj),
      .shift_code(shift_code), .rnd_en(rnd_en), .out_sel(out_sel),
      .p_a(p_a), .p_b(p_b), .ovf(ovf)
   );

   // ---------------- reference model ----------------
   function automatic longint ppv(input logic [15:0] a, input logic [15:0] b);
      if (a == 16'h8000 && b == 16'h8000) return 64'sd1073741823;
      return longint'($signed(a)) * longint'($signed(b));
   endfunction

   function automatic logic [15:0] cj(input logic [15:0] v, input logic c);
      return c ? 16'(-v) : v;
   endfunction

   function automatic logic [31:0] shf(input logic [31:0] s, input logic [1:0] c);
      case (c)
         2'b11:   return s << 1;
         2'b01:   return 32'($signed(s) >>> 1);
         2'b10:   return 32'($signed(s) >>> 2);
         default: return s;
      endcase
   endfunction

   function automatic logic [15:0] hiw(input logic [31:0] s, input logic r);
      logic [31:0] t;
      t = r ? s + 32'h8000 : s;
      return t[31:16];
   endfunction

   // model state: operand registers as the requirements describe them
   logic [15:0] m_xr = '0, m_xi = '0, m_yr = '0, m_yi = '0;

   task automatic model(output logic [31:0] re, output logic [31:0] im);
      re = 32'(ppv(m_xr, m_yr) - ppv(m_xi, m_yi));
      im = 32'(ppv(m_xr, m_yi) + ppv(m_xi, m_yr));
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // R7 R8 R9 R10: sweep the combinational controls on a held result
   task automatic check_all(input string tag, input logic [31:0] re, input logic [31:0] im);
      for (int c = 0; c < 4; c++) begin
         logic [31:0] sr, si;
         logic        r, eo;
         r  = 1'($urandom_range(0, 1));
         sr = shf(re, 2'(c));
         si = shf(im, 2'(c));
         eo = (c == 3) && ((re[31] ^ re[30]) || (im[31] ^ im[30]));
         shift_code = 2'(c);
         rnd_en = r;
         for (int s = 0; s < 4; s++) begin
            logic [15:0] ea, eb;
            case (s)
               0:       begin ea = hiw(sr, r); eb = hiw(si, r); end
               2:       begin ea = sr[15:0];   eb = si[15:0];   end
               1:       begin ea = hiw(sr, r); eb = sr[15:0];   end
               default: begin ea = hiw(si, r); eb = si[15:0];   end
            endcase
            out_sel = 2'(s);
            #1;
            check({tag, " R10 R7 R9 p_a"}, 32'(p_a), 32'(ea));
            check({tag, " R10 R7 R9 p_b"}, 32'(p_b), 32'(eb));
         end
         check({tag, " R8 ovf"}, 32'(ovf), 32'(eo));
      end
   endtask

   // load both operands, wait for the pipeline, then check (R3 R5)
   task automatic apply(input string tag, input logic [15:0] a, b, c, d, input logic cx, cy);
      logic [31:0] re, im;
      @(negedge clk);
      x_re = a; x_im = b; y_re = c; y_im = d; x_conj = cx; y_conj = cy;
      x_load_n = 1'b0; y_load_n = 1'b0;
      m_xr = a; m_xi = cj(b, cx); m_yr = c; m_yi = cj(d, cy);
      @(negedge clk);
      x_load_n = 1'b1; y_load_n = 1'b1; x_conj = 1'b0; y_conj = 1'b0;
      repeat (2) @(negedge clk);
      model(re, im);
      check_all({tag, " R5"}, re, im);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd4242));

      // R1: reset state on every slice
      repeat (3) @(negedge clk);
      for (int s = 0; s < 4; s++) begin
         out_sel = 2'(s);
         #1;
         check("R1 reset p_a", 32'(p_a), 32'h0);
         check("R1 reset p_b", 32'(p_b), 32'h0);
      end
      check("R1 reset ovf", 32'(ovf), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: every part at -1, all four products trapped
      apply("R4 all-min", 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0);
      // R4: only the real parts at -1
      apply("R4 re-min", 16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b0);
      // R5: largest magnitudes without a trap
      apply("R5 max", 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0);
      apply("R5 half", 16'h4000, 16'h4000, 16'h4000, 16'hC000, 1'b0, 1'b0);
      // R6: conjugation, including negation of the most negative code
      apply("R6 conj-x", 16'h1234, 16'h8000, 16'h8000, 16'h0F0F, 1'b1, 1'b0);
      apply("R6 conj-y", 16'h3000, 16'hD000, 16'h2000, 16'h1111, 1'b0, 1'b1);
      apply("R6 conj-both", 16'h0101, 16'hF00F, 16'h7000, 16'h9000, 1'b1, 1'b1);

      // R2: load Y only; X data and X conjugate on the port are ignored
      begin
         logic [31:0] re, im;
         @(negedge clk);
         x_re = 16'h5555; x_im = 16'hAAAA; x_conj = 1'b1;
         y_re = 16'h0F00; y_im = 16'hE123; y_load_n = 1'b0;
         m_yr = 16'h0F00; m_yi = 16'hE123;
         @(negedge clk);
         y_load_n = 1'b1; x_conj = 1'b0;
         repeat (2) @(negedge clk);
         model(re, im);
         check_all("R2 y-only", re, im);
         // R2: load X only; Y data and Y conjugate on the port are ignored
         @(negedge clk);
         x_re = 16'hC001; x_im = 16'h2222; x_load_n = 1'b0;
         y_re = 16'h7777; y_im = 16'h1111; y_conj = 1'b1;
         m_xr = 16'hC001; m_xi = 16'h2222;
         @(negedge clk);
         x_load_n = 1'b1; y_conj = 1'b0;
         repeat (2) @(negedge clk);
         model(re, im);
         check_all("R2 x-only", re, im);
      end

      // random held vectors
      for (int i = 0; i < 40; i++) begin
         apply("rand", 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      // R3: back-to-back stream, one result per cycle, two cycles after the operand register
      begin
         logic [31:0] exp_re [64];
         logic [31:0] exp_im [64];
         for (int j = 0; j < 64 + 3; j++) begin
            @(negedge clk);
            if (j >= 3) begin
               shift_code = 2'b00; rnd_en = 1'b0;
               out_sel = 2'b01;
               #1;
               check("R3 stream re", {p_a, p_b}, exp_re[j-3]);
               out_sel = 2'b11;
               #1;
               check("R3 stream im", {p_a, p_b}, exp_im[j-3]);
            end
            if (j < 64) begin
               logic [31:0] re, im;
               x_re = 16'($urandom); x_im = 16'($urandom);
               y_re = 16'($urandom); y_im = 16'($urandom);
               if (j % 7 == 0) begin x_re = 16'h8000; y_re = 16'h8000; end
               x_conj = 1'b0; y_conj = 1'b0;
               x_load_n = 1'b0; y_load_n = 1'b0;
               m_xr = x_re; m_xi = x_im; m_yr = y_re; m_yi = y_im;
               model(re, im);
               exp_re[j] = re;
               exp_im[j] = im;
            end else begin
               x_load_n = 1'b1; y_load_n = 1'b1;
            end
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule